// File: doc/BRIEF.md
# Table-Driven Raster Timing Sequencer

This block generates horizontal and vertical sync and blanking for a raster display. Each axis has a pixel or line counter and a small section register. The section register selects one word from a writable timing table. That word gives the count at which the section ends, the section that follows it, whether the counter restarts from zero on the way out, whether the change steps the other axis, and the sync and blank levels that apply while the section is held.

The horizontal axis advances on every clock. The vertical axis advances only in cycles where the horizontal axis leaves a section whose line-step flag is set. Both tables are written through one host port. Because the section order is read from the table, the sections can be placed at any table addresses and visited in any order.

The per-axis levels are brought out directly. They are also OR-combined into a composite blank and a composite sync for a RAMDAC. The horizontal count is cleared when the table says so, which is normally on entry to active video. Its value then equals the pixel number within the visible line.

Top module: `raster_seq_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, both section registers go to section 0 and `pix_x`, `line_y` and every sync and blank output go to 0 on the next clock edge.
- R2: Outside reset, `pix_x` grows by one on every clock, except on the clock that leaves a section whose clear flag is set.
- R3: A section ends on the clock where its counter equals the 12-bit end field of the current table word, bits [19:8]. The section register then takes the 4-bit next-section field, bits [7:4], of that same word. Any visiting order of table addresses works.
- R4: On leaving a section with the clear flag, bit 3, set, the counter becomes 0. When the clear flag is not set, the counter keeps counting up across the section change.
- R5: `hsync_o` and `hblank_o` carry the sync level, bit 1, and the blank level, bit 0, of the horizontal section that is held in the same cycle as the `pix_x` value on the port.
- R6: `line_y` and the vertical section follow the rules of R2 to R4. They change only on a clock where the horizontal axis leaves a section whose line-step flag, bit 2, is set. `vsync_o` and `vblank_o` come from the vertical table, with the same alignment as in R5.
- R7: `blank_o` is the OR of the horizontal and vertical blank levels. `csync_o` is the OR of the horizontal and vertical sync levels.
- R8: When `wr_en` is high, `wr_data` is written to the entry at `wr_addr`. `wr_sel` = 0 selects the horizontal table and `wr_sel` = 1 selects the vertical table. Writes are accepted while reset is held, and reset leaves the table contents unchanged.
- R9: A sync or blank level on an axis changes only when that axis's section changes, or when a table write was made in the two cycles before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host table write strobe |
| wr_sel | input | 1 | Table select: 0 horizontal, 1 vertical |
| wr_addr | input | SEC_W | Table entry (section number) |
| wr_data | input | CNT_W+SEC_W+4 | Table word {end, next, clear, step, sync, blank} |
| pix_x | output | CNT_W | Horizontal counter |
| line_y | output | CNT_W | Vertical counter |
| hsync_o | output | 1 | Horizontal sync level |
| hblank_o | output | 1 | Horizontal blank level |
| vsync_o | output | 1 | Vertical sync level |
| vblank_o | output | 1 | Vertical blank level |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Composite blank |

## Verification
The bench builds the block with the default CNT_W = 12 and SEC_W = 4, which gives 16-entry tables per axis. It programs lines only 16 to 18 pixels long and frames only 4 to 7 lines tall. That short timing lets several complete frames, and every line-step and wrap point in them, be compared cycle by cycle within a few hundred clocks. The second timing set places its sections at scattered addresses up to 9, so a design that steps through sections in address order instead of following the next-section field shows up at once. A reset in the middle of a frame, followed by a run with no new writes, shows that the tables survive reset.

// File: rtl/raster_seq_pkg.sv
package raster_seq_pkg;

    // Flag bits at the bottom of a table word; the next-section field
    // sits just above them and the end count at the top.
    localparam int FLAG_BLANK = 0;
    localparam int FLAG_SYNC  = 1;
    localparam int FLAG_STEP  = 2;
    localparam int FLAG_CLR   = 3;
    localparam int FLAG_W     = 4;

    // Number of timing axes: horizontal then vertical.
    localparam int NAXIS = 2;

    typedef enum logic {
        TBL_HORZ = 1'b0,
        TBL_VERT = 1'b1
    } tbl_sel_e;

    function automatic int tbl_word_w(input int cnt_w, input int sec_w);
        return cnt_w + sec_w + FLAG_W;
    endfunction

endpackage

// File: rtl/raster_seq_table.sv
module raster_seq_table
    import raster_seq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEC_W = 4,
    localparam int DEPTH  = 1 << SEC_W,
    localparam int WORD_W = CNT_W + SEC_W + FLAG_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SEC_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [SEC_W-1:0]  raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  logic [SEC_W-1:0]  raddr_b,
    output logic [1:0]        lvl_b
);

    // Plain register file: not reset, so a reset keeps the programmed timing.
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Port A: full word of the section being held.
    assign rdata_a = mem[raddr_a];

    // Port B: only the output levels of the section about to be held.
    assign lvl_b = {mem[raddr_b][FLAG_SYNC], mem[raddr_b][FLAG_BLANK]};

endmodule

// File: rtl/raster_seq_axis.sv
module raster_seq_axis
    import raster_seq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEC_W = 4,
    localparam int WORD_W = CNT_W + SEC_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [1:0]        nxt_lvl,
    output logic [SEC_W-1:0]  sec_q,
    output logic [SEC_W-1:0]  sec_d,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              sync_q,
    output logic              blank_q,
    output logic              step_o
);

    typedef struct packed {
        logic [CNT_W-1:0] stop;
        logic [SEC_W-1:0] nxt;
        logic             clr;
        logic             step;
        logic             sync;
        logic             blank;
    } tword_t;

    tword_t           cur;
    logic             hit;
    logic [CNT_W-1:0] cnt_d;

    assign cur = tword_t'(cur_word);

    always_comb begin
        hit   = adv && (cnt_q == cur.stop);
        sec_d = hit ? cur.nxt : sec_q;
        if (!adv) begin
            cnt_d = cnt_q;
        end else if (hit && cur.clr) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign step_o = hit && cur.step;

    // Levels are loaded from the entry of the section being entered, so
    // they line up with the section register and the counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            cnt_q   <= '0;
            sync_q  <= 1'b0;
            blank_q <= 1'b0;
        end else begin
            sec_q   <= sec_d;
            cnt_q   <= cnt_d;
            sync_q  <= nxt_lvl[1];
            blank_q <= nxt_lvl[0];
        end
    end

endmodule

// File: rtl/raster_seq_gen.sv
module raster_seq_gen
    import raster_seq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEC_W = 4,
    localparam int WORD_W = CNT_W + SEC_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [SEC_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y,
    output logic              hsync_o,
    output logic              hblank_o,
    output logic              vsync_o,
    output logic              vblank_o,
    output logic              csync_o,
    output logic              blank_o
);

    logic              adv_w   [NAXIS];
    logic              step_w  [NAXIS];
    logic [SEC_W-1:0]  sec_w   [NAXIS];
    logic [SEC_W-1:0]  secd_w  [NAXIS];
    logic [WORD_W-1:0] cur_w   [NAXIS];
    logic [1:0]        lvl_w   [NAXIS];
    logic [CNT_W-1:0]  cnt_w   [NAXIS];
    logic              sync_w  [NAXIS];
    logic              blank_w [NAXIS];
    logic              line_step;

    for (genvar g = 0; g < NAXIS; g++) begin : g_axis
        // The first axis runs every clock; each later axis is stepped by
        // the one before it.
        if (g == 0) begin : g_free
            assign adv_w[g] = 1'b1;
        end else begin : g_chained
            assign adv_w[g] = step_w[g-1];
        end

        raster_seq_table #(
            .CNT_W (CNT_W),
            .SEC_W (SEC_W)
        ) u_table (
            .clk     (clk),
            .we      (wr_en && (wr_sel == 1'(g))),
            .waddr   (wr_addr),
            .wdata   (wr_data),
            .raddr_a (sec_w[g]),
            .rdata_a (cur_w[g]),
            .raddr_b (secd_w[g]),
            .lvl_b   (lvl_w[g])
        );

        raster_seq_axis #(
            .CNT_W (CNT_W),
            .SEC_W (SEC_W)
        ) u_axis (
            .clk      (clk),
            .rst      (rst),
            .adv      (adv_w[g]),
            .cur_word (cur_w[g]),
            .nxt_lvl  (lvl_w[g]),
            .sec_q    (sec_w[g]),
            .sec_d    (secd_w[g]),
            .cnt_q    (cnt_w[g]),
            .sync_q   (sync_w[g]),
            .blank_q  (blank_w[g]),
            .step_o   (step_w[g])
        );
    end

    assign line_step = adv_w[int'(TBL_VERT)];

    assign pix_x    = cnt_w[int'(TBL_HORZ)];
    assign line_y   = cnt_w[int'(TBL_VERT)];
    assign hsync_o  = sync_w[int'(TBL_HORZ)];
    assign hblank_o = blank_w[int'(TBL_HORZ)];
    assign vsync_o  = sync_w[int'(TBL_VERT)];
    assign vblank_o = blank_w[int'(TBL_VERT)];
    assign csync_o  = hsync_o | vsync_o;
    assign blank_o  = hblank_o | vblank_o;

endmodule

// File: rtl/raster_seq_chk.sv
module raster_seq_chk #(
    parameter int CNT_W = 12,
    parameter int SEC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CNT_W-1:0] pix_x,
    input logic [CNT_W-1:0] line_y,
    input logic             hsync_o,
    input logic             hblank_o,
    input logic             vsync_o,
    input logic             vblank_o,
    input logic [SEC_W-1:0] h_sec,
    input logic             line_step,
    input logic             frame_step
);

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1: one edge with reset sampled high leaves everything idle.
    always @(negedge clk) begin
        if (rst_seen) begin
            assert_reset_idle_R1: assert (pix_x == '0 && line_y == '0 &&
                !hsync_o && !hblank_o && !vsync_o && !vblank_o)
                else $error("R1 outputs not idle after reset");
        end
    end

    // R2: a nonzero pixel count can only come from counting up.
    assert_pix_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_x != '0) |-> (pix_x == $past(pix_x) + 1'b1));

    // R6: the line count moves only on a horizontal line-step.
    assert_line_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(line_step) |-> $stable(line_y));

    // R6: the vertical axis can only leave a section on a line-step.
    assert_frame_gate_R6: assert property (@(posedge clk) disable iff (rst)
        frame_step |-> line_step);

    // R9: horizontal levels hold while the section and the table hold.
    assert_level_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $stable(h_sec) &&
         !$past(wr_en) && !$past(wr_en, 2))
        |-> ($stable(hsync_o) && $stable(hblank_o)));

endmodule

bind raster_seq_gen raster_seq_chk #(
    .CNT_W (CNT_W),
    .SEC_W (SEC_W)
) u_raster_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .pix_x      (pix_x),
    .line_y     (line_y),
    .hsync_o    (hsync_o),
    .hblank_o   (hblank_o),
    .vsync_o    (vsync_o),
    .vblank_o   (vblank_o),
    .h_sec      (sec_w[0]),
    .line_step  (line_step),
    .frame_step (step_w[1])
);

// File: tb/test_raster_seq_gen.sv
module test_raster_seq_gen;

    localparam int CNT_W  = 12;
    localparam int SEC_W  = 4;
    localparam int WORD_W = CNT_W + SEC_W + 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [SEC_W-1:0]  wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [CNT_W-1:0]  pix_x, line_y;
    logic hsync_o, hblank_o, vsync_o, vblank_o, csync_o, blank_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    raster_seq_gen #(.CNT_W(CNT_W), .SEC_W(SEC_W)) i_raster_seq_gen (
        .clk, .rst, .wr_en, .wr_sel, .wr_addr, .wr_data,
        .pix_x, .line_y, .hsync_o, .hblank_o, .vsync_o, .vblank_o,
        .csync_o, .blank_o
    );

    // Word layout per R3/R4/R5/R8: {end[19:8], next[7:4], clr, step, sync, blank}
    function automatic logic [WORD_W-1:0] mk(input int stop, input int nxt,
        input bit clr, input bit step, input bit sync, input bit blank);
        return {CNT_W'(stop), SEC_W'(nxt), clr, step, sync, blank};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wr(input bit sel, input int addr, input logic [WORD_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = SEC_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reset idle state, R1.
    task automatic t_reset_state();
        @(negedge clk);
        check("R1", "pix_x", int'(pix_x), 0);
        check("R1", "line_y", int'(line_y), 0);
        check("R1", "hsync", int'(hsync_o), 0);
        check("R1", "hblank", int'(hblank_o), 0);
        check("R1", "vsync", int'(vsync_o), 0);
        check("R1", "vblank", int'(vblank_o), 0);
        check("R1", "csync", int'(csync_o), 0);
        check("R1", "blank", int'(blank_o), 0);
    endtask

    // Drop reset at a falling edge, then compare every cycle against the
    // raster computed from the programmed timing.
    task automatic run_frames(input int ncyc, input int hlen, input int hb,
        input int hs0, input int hs1, input int vlen, input int vb,
        input int vs0, input int vs1);
        rst = 1'b0;
        for (int i = 1; i <= ncyc; i++) begin
            int hp, ln;
            bit hbx, hsx, vbx, vsx;
            @(negedge clk);
            hp  = i % hlen;
            ln  = (i / hlen) % vlen;
            hbx = (hp >= hb);
            hsx = (hp >= hs0) && (hp <= hs1);
            vbx = (ln >= vb);
            vsx = (ln >= vs0) && (ln <= vs1);
            check("R2_R4", "pix_x", int'(pix_x), hp);
            check("R6", "line_y", int'(line_y), ln);
            check("R5", "hblank", int'(hblank_o), int'(hbx));
            check("R3_R5", "hsync", int'(hsync_o), int'(hsx));
            check("R6", "vblank", int'(vblank_o), int'(vbx));
            check("R6", "vsync", int'(vsync_o), int'(vsx));
            check("R7", "blank", int'(blank_o), int'(hbx | vbx));
            check("R7", "csync", int'(csync_o), int'(hsx | vsx));
        end
    endtask

    // R8: tables written while reset is held; sequential sections.
    task automatic t_program_a();
        wr(1'b0, 0, mk(9,  1, 0, 0, 0, 0));
        wr(1'b0, 1, mk(11, 2, 0, 0, 0, 1));
        wr(1'b0, 2, mk(14, 3, 0, 0, 1, 1));
        wr(1'b0, 3, mk(17, 0, 1, 1, 0, 1));
        wr(1'b1, 0, mk(3,  1, 0, 0, 0, 0));
        wr(1'b1, 1, mk(4,  2, 0, 0, 0, 1));
        wr(1'b1, 2, mk(5,  3, 0, 0, 1, 1));
        wr(1'b1, 3, mk(6,  0, 1, 0, 0, 1));
        t_reset_state();
        run_frames(2 * 18 * 7, 18, 10, 12, 14, 7, 4, 5, 5);
    endtask

    // R3: scattered section addresses; the next field sets the order.
    task automatic t_program_b();
        @(negedge clk);
        rst = 1'b1;
        wr(1'b0, 0, mk(7,  5, 0, 0, 0, 0));
        wr(1'b0, 5, mk(9,  2, 0, 0, 0, 1));
        wr(1'b0, 2, mk(12, 7, 0, 0, 1, 1));
        wr(1'b0, 7, mk(15, 0, 1, 1, 0, 1));
        wr(1'b1, 0, mk(1,  4, 0, 0, 0, 0));
        wr(1'b1, 4, mk(2,  9, 0, 0, 1, 1));
        wr(1'b1, 9, mk(3,  0, 1, 0, 0, 1));
        t_reset_state();
        run_frames(3 * 16 * 4, 16, 8, 10, 12, 4, 2, 2, 2);
    endtask

    // R1, R8: reset mid-frame idles the block but keeps the tables.
    task automatic t_reset_keeps_table();
        repeat (37) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "pix_x mid-frame", int'(pix_x), 0);
        check("R1", "line_y mid-frame", int'(line_y), 0);
        check("R1", "blank mid-frame", int'(blank_o), 0);
        check("R1", "csync mid-frame", int'(csync_o), 0);
        run_frames(2 * 16 * 4, 16, 8, 10, 12, 4, 2, 2, 2);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_program_a();
        t_program_b();
        t_reset_keeps_table();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule